// File: doc/BRIEF.md
# Real-Time-Clock Interrupt Flag Generator

This block turns a slow polling tick of 64 Hz, together with the current hours, minutes and seconds from a separate time-of-day counter, into interrupt flags of the kind a real-time clock raises. It has three sources, and each has its own enable. The update source fires once for every change of the seconds value. The alarm source fires when the time equals a programmed hour, minute and second. The periodic source fires at a power-of-two rate between 2 Hz and 8192 Hz.

On any tick that raises at least one flag, the block registers a flag word and pulses an interrupt strobe for one cycle. The flag word holds a general interrupt bit and an event count of one in its upper byte. Service of the tick can be late. The tick source then reports how many ticks were missed, and the periodic divider adds that number before it counts the current tick, so that its phase stays correct.

For periodic rates of 64 Hz or lower, the tick is divided down. For faster rates, the block asks the tick source for a shorter interval through a separate output, and it raises the periodic flag on every tick. The block also outputs a tick request, which is high while any source is enabled. Counting the time of day and generating the tick are done outside this block.

Top module: `rtc_flag_gen`

## Requirements
- R1: Periodic rate code c (rate = 2^c Hz) in 1..6: with the periodic source enabled, flag word bit 6 is raised on every 2^(6-c)-th tick.
- R2: For rate code 7..13, bit 6 is raised on every tick. `tick_fast_o` is high while the periodic source is enabled with such a code.
- R3: A rate code below 1 is treated as 1, and a code above 13 is treated as 13.
- R4: `missed_i`, sampled with a tick, is added to the periodic count before that tick is counted.
- R5: The periodic count returns to zero when bit 6 is raised and when a rate code is written with `rate_wr_i`.
- R6: With the update source enabled, bit 4 is raised on a tick whose `sec_i` differs from the seconds value recorded at the previous enabled tick.
- R7: The first tick after the update source is enabled only records the seconds value and raises no flag.
- R8: With the alarm source enabled, bit 5 is raised on a tick where hour, minute and second all equal the alarm values.
- R9: `irq_o` pulses high in the cycle after the clock edge that samples a flag-raising tick. `flags_o` then has bit 7 set and bits 15:8 equal to 1, and it holds its value until the next pulse.
- R10: `tick_req_o` is high one cycle after any source enable is high, and low one cycle after all of them are low.
- R11: Without a tick, or with the relevant enable low, no flag is raised.
- R12: After reset, `irq_o`, `flags_o`, `tick_req_o` and the periodic count are zero, and the rate code is 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse of the polling tick |
| missed_i | input | 4 | Number of ticks missed before this one |
| sec_i | input | 6 | Current seconds |
| min_i | input | 6 | Current minutes |
| hour_i | input | 5 | Current hours |
| alm_sec_i | input | 6 | Alarm seconds |
| alm_min_i | input | 6 | Alarm minutes |
| alm_hour_i | input | 5 | Alarm hours |
| upd_en_i | input | 1 | Update source enable |
| alm_en_i | input | 1 | Alarm source enable |
| per_en_i | input | 1 | Periodic source enable |
| rate_wr_i | input | 1 | Write strobe for the rate code |
| rate_code_i | input | 4 | log2 of the periodic rate in Hz |
| irq_o | output | 1 | Interrupt strobe |
| flags_o | output | 16 | Flag word |
| tick_req_o | output | 1 | Tick source requested |
| tick_fast_o | output | 1 | Shorter tick interval requested |

## Verification
The bench builds the block with its default parameters: a base tick of 2^6 Hz, rate codes limited to 1..13, a missed-tick field of 4 bits, and the alarm comparator present. With these values the longest divide, 32 ticks at code 1, fits in a short directed run. Clamping can be reached from both ends of the 4-bit code field. A 4-bit missed count is large enough to overrun a whole periodic interval within a single tick.

// File: rtl/rtc_flag_pkg.sv
package rtc_flag_pkg;
   localparam int unsigned BIT_UPD = 4;
   localparam int unsigned BIT_ALM = 5;
   localparam int unsigned BIT_PER = 6;
   localparam int unsigned BIT_IRQ = 7;
   localparam int unsigned CNT_LSB = 8;

   typedef struct packed {
      logic per;
      logic alm;
      logic upd;
   } rtc_hits_t;
endpackage

// File: rtl/rtc_per_div.sv
module rtc_per_div #(
   parameter int unsigned BASE_LOG = 6,
   parameter int unsigned MIN_CODE = 1,
   parameter int unsigned MAX_CODE = 13,
   parameter int unsigned RATE_W   = 4,
   parameter int unsigned MISS_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              en_i,
   input  logic [MISS_W-1:0] missed_i,
   input  logic              wr_i,
   input  logic [RATE_W-1:0] code_i,
   output logic              hit_o,
   output logic              fast_o
);
   localparam int unsigned CNT_W = BASE_LOG + MISS_W + 2;

   logic [RATE_W-1:0] code_q;
   logic [RATE_W-1:0] code_clamped;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  sum;
   logic [CNT_W-1:0]  limit;

   always_comb begin
      if (code_i < RATE_W'(MIN_CODE))      code_clamped = RATE_W'(MIN_CODE);
      else if (code_i > RATE_W'(MAX_CODE)) code_clamped = RATE_W'(MAX_CODE);
      else                                 code_clamped = code_i;
   end

   always_comb begin
      if (code_q >= RATE_W'(BASE_LOG)) limit = CNT_W'(1);
      else limit = CNT_W'(1) << (RATE_W'(BASE_LOG) - code_q);
   end

   assign sum    = cnt_q + CNT_W'(missed_i) + CNT_W'(1);
   assign hit_o  = tick_i && en_i && !wr_i && (sum >= limit);
   assign fast_o = en_i && (code_q > RATE_W'(BASE_LOG));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q <= RATE_W'(BASE_LOG);
         cnt_q  <= '0;
      end else if (wr_i) begin
         code_q <= code_clamped;
         cnt_q  <= '0;
      end else if (tick_i && en_i) begin
         cnt_q <= (sum >= limit) ? '0 : sum;
      end
   end
endmodule

// File: rtl/rtc_upd_det.sv
module rtc_upd_det #(
   parameter int unsigned SEC_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             en_i,
   input  logic [SEC_W-1:0] sec_i,
   output logic             hit_o
);
   logic [SEC_W-1:0] last_q;
   logic             valid_q;

   assign hit_o = tick_i && en_i && valid_q && (sec_i != last_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_q  <= '0;
         valid_q <= 1'b0;
      end else if (!en_i) begin
         valid_q <= 1'b0;
      end else if (tick_i) begin
         last_q  <= sec_i;
         valid_q <= 1'b1;
      end
   end
endmodule

// File: rtl/rtc_alm_cmp.sv
module rtc_alm_cmp #(
   parameter int unsigned HOUR_W = 5,
   parameter int unsigned MIN_W  = 6,
   parameter int unsigned SEC_W  = 6
) (
   input  logic              tick_i,
   input  logic              en_i,
   input  logic [HOUR_W-1:0] hour_i,
   input  logic [MIN_W-1:0]  min_i,
   input  logic [SEC_W-1:0]  sec_i,
   input  logic [HOUR_W-1:0] a_hour_i,
   input  logic [MIN_W-1:0]  a_min_i,
   input  logic [SEC_W-1:0]  a_sec_i,
   output logic              hit_o
);
   localparam int unsigned NF = 3;
   logic [NF-1:0] eq;

   for (genvar f = 0; f < NF; f++) begin : g_field
      if (f == 0) begin : g_s
         assign eq[f] = (sec_i == a_sec_i);
      end else if (f == 1) begin : g_m
         assign eq[f] = (min_i == a_min_i);
      end else begin : g_h
         assign eq[f] = (hour_i == a_hour_i);
      end
   end

   assign hit_o = tick_i && en_i && (&eq);
endmodule

// File: rtl/rtc_flag_gen.sv
module rtc_flag_gen #(
   parameter int unsigned BASE_LOG  = 6,
   parameter int unsigned MIN_CODE  = 1,
   parameter int unsigned MAX_CODE  = 13,
   parameter int unsigned RATE_W    = 4,
   parameter int unsigned MISS_W    = 4,
   parameter int unsigned HOUR_W    = 5,
   parameter int unsigned MIN_W     = 6,
   parameter int unsigned SEC_W     = 6,
   parameter int unsigned WORD_W    = 16,
   parameter bit          HAS_ALARM = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [MISS_W-1:0] missed_i,
   input  logic [SEC_W-1:0]  sec_i,
   input  logic [MIN_W-1:0]  min_i,
   input  logic [HOUR_W-1:0] hour_i,
   input  logic [SEC_W-1:0]  alm_sec_i,
   input  logic [MIN_W-1:0]  alm_min_i,
   input  logic [HOUR_W-1:0] alm_hour_i,
   input  logic              upd_en_i,
   input  logic              alm_en_i,
   input  logic              per_en_i,
   input  logic              rate_wr_i,
   input  logic [RATE_W-1:0] rate_code_i,
   output logic              irq_o,
   output logic [WORD_W-1:0] flags_o,
   output logic              tick_req_o,
   output logic              tick_fast_o
);
   import rtc_flag_pkg::*;

   localparam int unsigned CNT_FIELD_W = WORD_W - CNT_LSB;

   if (WORD_W <= CNT_LSB) begin : g_bad_word
      $error("WORD_W must leave room for the event count");
   end
   if (MIN_CODE == 0 || MIN_CODE > BASE_LOG || MAX_CODE < BASE_LOG) begin : g_bad_code
      $error("rate code range must straddle BASE_LOG");
   end
   if ((1 << RATE_W) <= MAX_CODE) begin : g_bad_rate_w
      $error("RATE_W too narrow for MAX_CODE");
   end

   rtc_hits_t hits;

   rtc_per_div #(
      .BASE_LOG(BASE_LOG), .MIN_CODE(MIN_CODE), .MAX_CODE(MAX_CODE),
      .RATE_W(RATE_W), .MISS_W(MISS_W)
   ) i_per (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .en_i(per_en_i),
      .missed_i(missed_i), .wr_i(rate_wr_i), .code_i(rate_code_i),
      .hit_o(hits.per), .fast_o(tick_fast_o)
   );

   rtc_upd_det #(.SEC_W(SEC_W)) i_upd (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .en_i(upd_en_i),
      .sec_i(sec_i), .hit_o(hits.upd)
   );

   if (HAS_ALARM) begin : g_alm
      rtc_alm_cmp #(.HOUR_W(HOUR_W), .MIN_W(MIN_W), .SEC_W(SEC_W)) i_alm (
         .tick_i(tick_i), .en_i(alm_en_i),
         .hour_i(hour_i), .min_i(min_i), .sec_i(sec_i),
         .a_hour_i(alm_hour_i), .a_min_i(alm_min_i), .a_sec_i(alm_sec_i),
         .hit_o(hits.alm)
      );
   end else begin : g_no_alm
      assign hits.alm = 1'b0;
   end

   logic [WORD_W-1:0] word_next;

   always_comb begin
      word_next                              = '0;
      word_next[BIT_UPD]                     = hits.upd;
      word_next[BIT_ALM]                     = hits.alm;
      word_next[BIT_PER]                     = hits.per;
      word_next[BIT_IRQ]                     = 1'b1;
      word_next[WORD_W-1:CNT_LSB]            = CNT_FIELD_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_o      <= 1'b0;
         flags_o    <= '0;
         tick_req_o <= 1'b0;
      end else begin
         irq_o      <= |hits;
         tick_req_o <= upd_en_i | alm_en_i | per_en_i;
         if (|hits) flags_o <= word_next;
      end
   end
endmodule

// File: rtl/rtc_flag_gen_chk.sv
module rtc_flag_gen_chk #(
   parameter int unsigned MISS_W = 4,
   parameter int unsigned HOUR_W = 5,
   parameter int unsigned MIN_W  = 6,
   parameter int unsigned SEC_W  = 6,
   parameter int unsigned RATE_W = 4,
   parameter int unsigned WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_i,
   input logic [SEC_W-1:0]  sec_i,
   input logic [MIN_W-1:0]  min_i,
   input logic [HOUR_W-1:0] hour_i,
   input logic [SEC_W-1:0]  alm_sec_i,
   input logic [MIN_W-1:0]  alm_min_i,
   input logic [HOUR_W-1:0] alm_hour_i,
   input logic              upd_en_i,
   input logic              alm_en_i,
   input logic              per_en_i,
   input logic              rate_wr_i,
   input logic              irq_o,
   input logic [WORD_W-1:0] flags_o,
   input logic              tick_req_o,
   input logic              tick_fast_o
);
   // R9: a strobe only follows a sampled tick
   a_r9_strobe_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(tick_i));

   // R9: word layout on each strobe
   a_r9_word_layout: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (flags_o[7] && flags_o[WORD_W-1:8] == 1));

   // R9: word holds between strobes
   a_r9_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_o |-> $stable(flags_o));

   // R8: alarm bit requires an enabled match on the sampled tick
   a_r8_alarm_match: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && flags_o[5]) |-> $past(alm_en_i && tick_i && sec_i == alm_sec_i
                                      && min_i == alm_min_i && hour_i == alm_hour_i));

   // R6: update bit requires the update source enabled
   a_r6_update_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && flags_o[4]) |-> $past(upd_en_i && tick_i));

   // R2: fast mode flags every tick
   a_r2_fast_every_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && per_en_i && tick_fast_o && !rate_wr_i) |=> (irq_o && flags_o[6]));

   // R10: no enable means no tick request
   a_r10_req_off: assert property (@(posedge clk) disable iff (!rst_n)
      !(upd_en_i || alm_en_i || per_en_i) |=> !tick_req_o);

   // R11: nothing fires without a tick
   a_r11_no_tick_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> !irq_o);
endmodule

bind rtc_flag_gen rtc_flag_gen_chk #(
   .MISS_W(MISS_W), .HOUR_W(HOUR_W), .MIN_W(MIN_W), .SEC_W(SEC_W),
   .RATE_W(RATE_W), .WORD_W(WORD_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
   .sec_i(sec_i), .min_i(min_i), .hour_i(hour_i),
   .alm_sec_i(alm_sec_i), .alm_min_i(alm_min_i), .alm_hour_i(alm_hour_i),
   .upd_en_i(upd_en_i), .alm_en_i(alm_en_i), .per_en_i(per_en_i),
   .rate_wr_i(rate_wr_i), .irq_o(irq_o), .flags_o(flags_o),
   .tick_req_o(tick_req_o), .tick_fast_o(tick_fast_o)
);

// File: tb/test_rtc_flag_gen.sv
`timescale 1ns/1ps
module test_rtc_flag_gen;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        tick = 0;
   logic [3:0]  missed = 0;
   logic [5:0]  sec = 0, mn = 0, a_sec = 0, a_min = 0;
   logic [4:0]  hr = 0, a_hour = 0;
   logic        upd_en = 0, alm_en = 0, per_en = 0;
   logic        rate_wr = 0;
   logic [3:0]  rate_code = 0;
   logic        irq;
   logic [15:0] flags;
   logic        tick_req, tick_fast;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   rtc_flag_gen i_rtc_flag_gen (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .missed_i(missed),
      .sec_i(sec), .min_i(mn), .hour_i(hr),
      .alm_sec_i(a_sec), .alm_min_i(a_min), .alm_hour_i(a_hour),
      .upd_en_i(upd_en), .alm_en_i(alm_en), .per_en_i(per_en),
      .rate_wr_i(rate_wr), .rate_code_i(rate_code),
      .irq_o(irq), .flags_o(flags), .tick_req_o(tick_req), .tick_fast_o(tick_fast)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one tick; returns strobe and word seen after the sampling edge
   task automatic do_tick(input logic [3:0] m, output logic s, output logic [15:0] w);
      @(negedge clk); tick = 1; missed = m;
      @(posedge clk); #1; s = irq; w = flags;
      @(negedge clk); tick = 0; missed = 0;
   endtask

   task automatic set_rate(input logic [3:0] c);
      @(negedge clk); rate_wr = 1; rate_code = c;
      @(negedge clk); rate_wr = 0;
   endtask

   // ticks n-1 times expecting no periodic flag, then once expecting it
   task automatic per_run(input int n, input string req);
      logic s; logic [15:0] w; int early = 0;
      for (int i = 1; i < n; i++) begin
         do_tick(0, s, w);
         if (s) early++;
      end
      chk({req, " quiet ticks"}, early, 0);
      do_tick(0, s, w);
      chk({req, " strobe"}, s, 1);
      chk({req, " word"}, w, 16'h01C0);
   endtask

   task automatic t_reset;
      chk("R12 irq", irq, 0);
      chk("R12 flags", flags, 0);
      chk("R12 tick_req", tick_req, 0);
      chk("R12 tick_fast", tick_fast, 0);
   endtask

   task automatic t_slow;
      per_en = 1;
      set_rate(4);
      per_run(4, "R1 16Hz");
      per_run(4, "R5 count cleared after flag");
      chk("R2 no fast at 16Hz", tick_fast, 0);
      set_rate(1);
      per_run(32, "R1 2Hz");
   endtask

   task automatic t_missed;
      logic s; logic [15:0] w;
      set_rate(4);
      do_tick(2, s, w);
      chk("R4 missed 2 no flag", s, 0);
      do_tick(0, s, w);
      chk("R4 missed then tick flags", s, 1);
      do_tick(3, s, w);
      chk("R4 missed 3 flags at once", s, 1);
   endtask

   task automatic t_rewrite;
      logic s; logic [15:0] w; int early = 0;
      set_rate(3);
      for (int i = 0; i < 5; i++) begin do_tick(0, s, w); if (s) early++; end
      chk("R5 pre-rewrite quiet", early, 0);
      set_rate(3);
      per_run(8, "R5 rewrite resets count");
   endtask

   task automatic t_fast;
      logic s; logic [15:0] w;
      set_rate(8);
      #1 chk("R2 fast flag", tick_fast, 1);
      do_tick(0, s, w); chk("R2 fast tick1", s, 1);
      do_tick(0, s, w); chk("R2 fast tick2", s, 1);
      chk("R2 fast word", w, 16'h01C0);
   endtask

   task automatic t_clamp;
      set_rate(15);
      #1 chk("R3 high code clamps to fast", tick_fast, 1);
      set_rate(0);
      #1 chk("R3 low code not fast", tick_fast, 0);
      per_run(32, "R3 low code as 2Hz");
      per_en = 0;
   endtask

   task automatic t_update;
      logic s; logic [15:0] w;
      upd_en = 1; sec = 10;
      do_tick(0, s, w); chk("R7 first tick silent", s, 0);
      do_tick(0, s, w); chk("R6 same second silent", s, 0);
      sec = 11;
      do_tick(0, s, w); chk("R6 second changed", s, 1);
      chk("R6 word", w, 16'h0190);
      @(negedge clk); upd_en = 0;
      @(negedge clk); upd_en = 1; sec = 12;
      do_tick(0, s, w); chk("R7 re-enable silent", s, 0);
      sec = 13;
      do_tick(0, s, w); chk("R6 after re-enable", s, 1);
      upd_en = 0; sec = 20;
      do_tick(0, s, w); chk("R11 update disabled", s, 0);
      chk("R9 word held", flags, 16'h0190);
   endtask

   task automatic t_alarm;
      logic s; logic [15:0] w;
      a_hour = 1; a_min = 2; a_sec = 3;
      hr = 1; mn = 2; sec = 3;
      do_tick(0, s, w); chk("R11 alarm disabled", s, 0);
      alm_en = 1;
      do_tick(0, s, w); chk("R8 alarm match", s, 1);
      chk("R8 word", w, 16'h01A0);
      @(negedge clk); @(posedge clk); #1;
      chk("R9 strobe one cycle", irq, 0);
      chk("R9 word kept", flags, 16'h01A0);
      mn = 3;
      do_tick(0, s, w); chk("R8 minute mismatch", s, 0);
      mn = 2;
      @(posedge clk); #1; chk("R11 no tick with match", irq, 0);
   endtask

   task automatic t_all;
      logic s; logic [15:0] w;
      upd_en = 1; sec = 3;
      do_tick(0, s, w);
      per_en = 1; set_rate(8);
      a_sec = 4; sec = 4;
      do_tick(0, s, w);
      chk("R9 all three", w, 16'h01F0);
   endtask

   task automatic t_req;
      @(posedge clk); #1; chk("R10 req on", tick_req, 1);
      @(negedge clk); upd_en = 0; alm_en = 0; per_en = 0;
      @(posedge clk); #1; chk("R10 req off", tick_req, 0);
      chk("R2 fast off when disabled", tick_fast, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 t_reset();
      @(negedge clk); rst_n = 1;
      t_slow();
      t_missed();
      t_rewrite();
      t_fast();
      t_clamp();
      t_update();
      t_alarm();
      t_all();
      t_req();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule